// File: doc/BRIEF.md
# LCD panel init sequencer

This block brings a small TFT display controller out of power-up without any help from software. After the chip-level reset it holds the panel reset line active, then releases it. It counts fixed settle intervals on a millisecond tick. It then plays a fixed bring-up script of command and parameter bytes over a write-only three-wire serial link. The script covers wake-up, addressing, pixel format, porches, voltages, both gamma tables, inversion and the RGB-interface setup.

Every byte travels as a 9-bit word. The leading bit tells the panel whether the byte is a command or a parameter. When the script has finished, the block raises `ready`. From then on, single-cycle request strobes send the display-on, display-off or sleep-entry command. Strobes that arrive while `ready` is low are dropped.

Top module: `lcd_init_seq`

## Requirements
- R1: Each serial word is 9 bits long and is sent MSB first. Bit 8 is 0 for a command and 1 for a parameter, and bits 7:0 hold the byte. Chip select stays low for the whole word. Data changes only while the serial clock falls, so it is stable at each rising edge, where the panel samples it.
- R2: After reset the panel reset output is high, and no word is sent while it is high. It stays high for RESET_MS ticks (default 30).
- R3: After the panel reset output is released, SETTLE_MS ticks (default 120) pass before the first word starts.
- R4: The first word is command 0x11 (sleep-out). WAKE_MS ticks (default 120) pass between the end of that word and the start of the next one. No other word is followed by a tick wait.
- R5: The configuration part of the script follows sleep-out, in this order:
  - 0x36 with parameter 0x00
  - 0x3A with 0x66
  - 0xB2 with 0x0C, 0x0C, 0x00, 0x33, 0x33
  - 0xB7 with 0x35
  - 0xBB with 0x2B
  - 0xC0 with 0x2C
  - 0xC2 with 0x01
  - 0xC3 with 0x0F
  - 0xC4 with 0x20
  - 0xC6 with 0x0F
  - 0xD0 with 0xA4, 0xA1
- R6: Two gamma tables come next, each a command followed by 14 parameters.
  - 0xE0: D0 0A 0E 08 09 07 2D 33 3D 34 0A 0A 1B 28
  - 0xE1: D0 0A 0F 08 08 07 2E 54 40 34 09 0B 1B 28
- R7: The script ends with invert-on 0x21, which carries no parameters. It is followed by 0xB0 with 0x11, 0xF0, and then by 0xB1 with 0xCE, 0x08, 0x14. That makes 66 words in total.
- R8: `ready` is low until the last script word has completed. While `ready` is high, chip select is high and the panel reset output is low.
- R9: While `ready` is high, a strobe sends exactly one command word, and `ready` returns high after that word.
  - `disp_on_req` sends 0x29.
  - `disp_off_req` sends 0x28.
  - `sleep_req` sends 0x10.
  - `ready` falls in the cycle after the accepted strobe.
- R10: A request strobe that arrives while `ready` is low has no effect. This covers strobes during initialisation and strobes while a requested command is still being sent.
- R11: When several strobes arrive in the same ready cycle, only one word is sent. Sleep-in has the highest priority, then display-off, then display-on.
- R12: The serial clock is low whenever chip select is high. Chip select returns high between consecutive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| disp_on_req | input | 1 | Display-on request strobe |
| disp_off_req | input | 1 | Display-off request strobe |
| sleep_req | input | 1 | Sleep-entry request strobe |
| lcd_rst | output | 1 | Panel reset, active high |
| lcd_cs_n | output | 1 | Serial chip select, active low |
| lcd_sclk | output | 1 | Serial clock, idle low |
| lcd_sdat | output | 1 | Serial data |
| ready | output | 1 | Initialisation done and no request in flight |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is two or three request strobes. The bench raises them in one cycle while `ready` is high. The decoded serial stream must then contain exactly one word, the one with the highest priority.

The second pair is a fresh strobe arriving while the previous request is still on the wire. The bench sends the second strobe a few cycles after an accepted one. It then checks that the word count rises by one only.

A display-on strobe is also given during the settle wait. The bench checks that the script still starts with sleep-out and holds exactly 66 words when `ready` rises.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int LINK_W     = 9;
  localparam int SCRIPT_LEN = 66;
  localparam int SCRIPT_IW  = $clog2(SCRIPT_LEN);

  // one script slot: end marker, tick wait after it, and the serial word
  typedef struct packed {
    logic              last;
    logic              hold;
    logic [LINK_W-1:0] word;
  } script_ent_t;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_RST_HOLD,
    ST_SETTLE,
    ST_LOAD,
    ST_SEND,
    ST_WAKE,
    ST_READY,
    ST_REQ_GO,
    ST_REQ_SEND
  } seq_state_t;

  localparam logic [7:0] OP_SLEEP_IN  = 8'h10;
  localparam logic [7:0] OP_DISP_OFF  = 8'h28;
  localparam logic [7:0] OP_DISP_ON   = 8'h29;

endpackage

// File: rtl/lcd_script_rom.sv
module lcd_script_rom
  import lcd_init_pkg::*;
#(
  parameter int IDX_W = SCRIPT_IW
) (
  input  logic [IDX_W-1:0] idx,
  output script_ent_t      ent
);

  localparam int POS_BASE = 29;
  localparam int NEG_BASE = 44;
  localparam int GAM_LEN  = 14;
  localparam int LAST_IDX = SCRIPT_LEN - 1;
  localparam int WAKE_IDX = 0;

  // gamma tables: neg selects the negative-polarity set
  function automatic logic [7:0] gamma_byte(input logic neg, input logic [3:0] k);
    logic [7:0] b;
    case ({neg, k})
      5'h00, 5'h10: b = 8'hD0;
      5'h01, 5'h11: b = 8'h0A;
      5'h02:        b = 8'h0E;
      5'h12:        b = 8'h0F;
      5'h03, 5'h13: b = 8'h08;
      5'h04:        b = 8'h09;
      5'h14:        b = 8'h08;
      5'h05, 5'h15: b = 8'h07;
      5'h06:        b = 8'h2D;
      5'h16:        b = 8'h2E;
      5'h07:        b = 8'h33;
      5'h17:        b = 8'h54;
      5'h08:        b = 8'h3D;
      5'h18:        b = 8'h40;
      5'h09, 5'h19: b = 8'h34;
      5'h0A:        b = 8'h0A;
      5'h1A:        b = 8'h09;
      5'h0B:        b = 8'h0A;
      5'h1B:        b = 8'h0B;
      5'h0C, 5'h1C: b = 8'h1B;
      5'h0D, 5'h1D: b = 8'h28;
      default:      b = 8'h00;
    endcase
    return b;
  endfunction

  logic             in_pos, in_neg;
  logic [IDX_W-1:0] off_pos, off_neg;
  logic [3:0]       gk;
  logic [8:0]       main_word;

  always_comb begin
    in_pos  = (int'(idx) >= POS_BASE) && (int'(idx) < POS_BASE + GAM_LEN);
    in_neg  = (int'(idx) >= NEG_BASE) && (int'(idx) < NEG_BASE + GAM_LEN);
    off_pos = idx - IDX_W'(POS_BASE);
    off_neg = idx - IDX_W'(NEG_BASE);
    gk      = in_neg ? off_neg[3:0] : off_pos[3:0];
  end

  // command words carry bit 8 = 0, parameters bit 8 = 1
  always_comb begin
    case (int'(idx))
      0:  main_word = 9'h011;
      1:  main_word = 9'h036;  2:  main_word = 9'h100;
      3:  main_word = 9'h03A;  4:  main_word = 9'h166;
      5:  main_word = 9'h0B2;  6:  main_word = 9'h10C;
      7:  main_word = 9'h10C;  8:  main_word = 9'h100;
      9:  main_word = 9'h133;  10: main_word = 9'h133;
      11: main_word = 9'h0B7;  12: main_word = 9'h135;
      13: main_word = 9'h0BB;  14: main_word = 9'h12B;
      15: main_word = 9'h0C0;  16: main_word = 9'h12C;
      17: main_word = 9'h0C2;  18: main_word = 9'h101;
      19: main_word = 9'h0C3;  20: main_word = 9'h10F;
      21: main_word = 9'h0C4;  22: main_word = 9'h120;
      23: main_word = 9'h0C6;  24: main_word = 9'h10F;
      25: main_word = 9'h0D0;  26: main_word = 9'h1A4;
      27: main_word = 9'h1A1;
      28: main_word = 9'h0E0;
      43: main_word = 9'h0E1;
      58: main_word = 9'h021;
      59: main_word = 9'h0B0;  60: main_word = 9'h111;
      61: main_word = 9'h1F0;
      62: main_word = 9'h0B1;  63: main_word = 9'h1CE;
      64: main_word = 9'h108;  65: main_word = 9'h114;
      default: main_word = 9'h000;
    endcase
  end

  always_comb begin
    ent.word = (in_pos || in_neg) ? {1'b1, gamma_byte(in_neg, gk)} : main_word;
    ent.hold = (int'(idx) == WAKE_IDX);
    ent.last = (int'(idx) == LAST_IDX);
  end

endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             tick,
  output logic             expired
);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic             busy_q, busy_d;
  logic             exp_q, exp_d;

  always_comb begin
    rem_d  = rem_q;
    busy_d = busy_q;
    exp_d  = 1'b0;
    if (start) begin
      rem_d  = len;
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      if (rem_q <= CNT_W'(1)) begin
        rem_d  = '0;
        busy_d = 1'b0;
        exp_d  = 1'b1;
      end else begin
        rem_d = rem_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      busy_q <= busy_d;
      exp_q  <= exp_d;
    end
  end

  assign expired = exp_q;

  AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> $past(tick)); // R3

endmodule

// File: rtl/lcd_spi9_tx.sv
module lcd_spi9_tx #(
  parameter int W   = 9,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] word,
  output logic         busy,
  output logic         done,
  output logic         cs_n,
  output logic         sclk,
  output logic         sdat
);

  localparam int HC_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BC_W = $clog2(W);

  logic            cs_q, cs_d;
  logic            sclk_q, sclk_d;
  logic [W-1:0]    sh_q, sh_d;
  logic [BC_W-1:0] bit_q, bit_d;
  logic [HC_W-1:0] hc_q, hc_d;
  logic            done_q, done_d;

  always_comb begin
    cs_d   = cs_q;
    sclk_d = sclk_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    hc_d   = hc_q;
    done_d = 1'b0;
    if (cs_q) begin
      if (start) begin
        cs_d   = 1'b0;
        sclk_d = 1'b0;
        sh_d   = word;
        bit_d  = '0;
        hc_d   = HC_W'(DIV - 1);
      end
    end else if (hc_q == '0) begin
      hc_d = HC_W'(DIV - 1);
      if (!sclk_q) begin
        sclk_d = 1'b1;
      end else begin
        sclk_d = 1'b0;
        if (bit_q == BC_W'(W - 1)) begin
          cs_d   = 1'b1;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + BC_W'(1);
          sh_d  = {sh_q[W-2:0], 1'b0};
        end
      end
    end else begin
      hc_d = hc_q - HC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      hc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      hc_q   <= hc_d;
      done_q <= done_d;
    end
  end

  assign busy = !cs_q;
  assign done = done_q;
  assign cs_n = cs_q;
  assign sclk = sclk_q;
  assign sdat = sh_q[W-1];

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q); // R12
  AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && $rose(sclk_q)) |-> $stable(sh_q[W-1])); // R1

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int RESET_MS  = 30,
  parameter int SETTLE_MS = 120,
  parameter int WAKE_MS   = 120,
  parameter int SCLK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic disp_on_req,
  input  logic disp_off_req,
  input  logic sleep_req,
  output logic lcd_rst,
  output logic lcd_cs_n,
  output logic lcd_sclk,
  output logic lcd_sdat,
  output logic ready
);

  localparam int MAX_MS = (RESET_MS > SETTLE_MS) ?
                          ((RESET_MS > WAKE_MS) ? RESET_MS : WAKE_MS) :
                          ((SETTLE_MS > WAKE_MS) ? SETTLE_MS : WAKE_MS);
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  seq_state_t            state_q, state_d;
  logic [SCRIPT_IW-1:0]  idx_q, idx_d;
  logic [7:0]            cmd_q, cmd_d;
  logic                  rst_q, rst_d;

  script_ent_t           ent;
  logic                  tm_start, tm_exp;
  logic [CNT_W-1:0]      tm_len;
  logic                  tx_start, tx_busy, tx_done;
  logic [LINK_W-1:0]     tx_word;
  logic                  any_req;

  lcd_script_rom #(.IDX_W(SCRIPT_IW)) u_rom (
    .idx (idx_q),
    .ent (ent)
  );

  lcd_ms_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tm_start),
    .len     (tm_len),
    .tick    (ms_tick),
    .expired (tm_exp)
  );

  lcd_spi9_tx #(.W(LINK_W), .DIV(SCLK_HALF)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .word  (tx_word),
    .busy  (tx_busy),
    .done  (tx_done),
    .cs_n  (lcd_cs_n),
    .sclk  (lcd_sclk),
    .sdat  (lcd_sdat)
  );

  assign any_req = disp_on_req | disp_off_req | sleep_req;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cmd_d    = cmd_q;
    tm_start = 1'b0;
    tm_len   = '0;
    tx_start = 1'b0;
    tx_word  = ent.word;
    case (state_q)
      ST_BOOT: begin
        tm_start = 1'b1;
        tm_len   = CNT_W'(RESET_MS);
        state_d  = ST_RST_HOLD;
      end
      ST_RST_HOLD: if (tm_exp) begin
        tm_start = 1'b1;
        tm_len   = CNT_W'(SETTLE_MS);
        state_d  = ST_SETTLE;
      end
      ST_SETTLE: if (tm_exp) state_d = ST_LOAD;
      ST_LOAD: begin
        tx_start = 1'b1;
        state_d  = ST_SEND;
      end
      ST_SEND: if (tx_done) begin
        if (ent.last) begin
          state_d = ST_READY;
        end else begin
          idx_d = idx_q + SCRIPT_IW'(1);
          if (ent.hold) begin
            tm_start = 1'b1;
            tm_len   = CNT_W'(WAKE_MS);
            state_d  = ST_WAKE;
          end else begin
            state_d = ST_LOAD;
          end
        end
      end
      ST_WAKE: if (tm_exp) state_d = ST_LOAD;
      ST_READY: if (any_req) begin
        if (sleep_req)         cmd_d = OP_SLEEP_IN;
        else if (disp_off_req) cmd_d = OP_DISP_OFF;
        else                   cmd_d = OP_DISP_ON;
        state_d = ST_REQ_GO;
      end
      ST_REQ_GO: begin
        tx_start = 1'b1;
        tx_word  = {1'b0, cmd_q};
        state_d  = ST_REQ_SEND;
      end
      ST_REQ_SEND: if (tx_done) state_d = ST_READY;
      default: state_d = ST_BOOT;
    endcase
    rst_d = (state_d == ST_BOOT) || (state_d == ST_RST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      idx_q   <= '0;
      cmd_q   <= '0;
      rst_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cmd_q   <= cmd_d;
      rst_q   <= rst_d;
    end
  end

  assign lcd_rst = rst_q;
  assign ready   = (state_q == ST_READY);

  AST_NO_WORD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rst |-> lcd_cs_n); // R2
  AST_READY_LINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (lcd_cs_n && !lcd_rst)); // R8
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !tx_busy); // R10
  AST_REQ_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && any_req) |=> !ready); // R9

endmodule

// File: tb/lcd_init_seq_test.sv
module lcd_init_seq_test;

  logic clk = 1'b0;
  logic rst_n;
  logic ms_tick = 1'b0;
  logic disp_on_req, disp_off_req, sleep_req;
  logic lcd_rst, lcd_cs_n, lcd_sclk, lcd_sdat, ready;

  always #5 clk = ~clk;

  lcd_init_seq uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_tick      (ms_tick),
    .disp_on_req  (disp_on_req),
    .disp_off_req (disp_off_req),
    .sleep_req    (sleep_req),
    .lcd_rst      (lcd_rst),
    .lcd_cs_n     (lcd_cs_n),
    .lcd_sclk     (lcd_sclk),
    .lcd_sdat     (lcd_sdat),
    .ready        (ready)
  );

  int n_chk = 0;
  int n_fail = 0;
  int tick_cnt = 0;
  int n_words = 0;
  int rst_tick0 = 0;
  int rel_tick = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  int         ws_tick[$];
  int         we_tick[$];
  logic [8:0] sh = '0;
  int         nbits = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_rst = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add(input logic [7:0] op, input int n,
                     input logic [8*14-1:0] prm, input string tag);
    exp_q.push_back({1'b0, op}); tag_q.push_back(tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({1'b1, prm[8*(n-1-i) +: 8]});
      tag_q.push_back(tag);
    end
  endtask

  task automatic pulse(input logic on, input logic off, input logic slp);
    @(negedge clk);
    disp_on_req = on; disp_off_req = off; sleep_req = slp;
    @(negedge clk);
    disp_on_req = 1'b0; disp_off_req = 1'b0; sleep_req = 1'b0;
  endtask

  task automatic wait_ready_settled();
    @(negedge clk);
    while (!ready) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  // millisecond tick, counted as the design sees it
  initial forever begin
    repeat (49) @(negedge clk);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
  end
  always @(posedge clk) if (ms_tick) tick_cnt <= tick_cnt + 1;

  // serial decoder and per-clock reference checks
  always @(negedge clk) begin
    if (rst_n) begin
      if (!lcd_cs_n && lcd_sclk && !prev_sclk) begin
        sh = {sh[7:0], lcd_sdat};
        nbits++;
      end
      if (prev_cs && !lcd_cs_n) begin
        ws_tick.push_back(tick_cnt);
        sh = '0;
        nbits = 0;
      end
      if (!prev_cs && lcd_cs_n) begin
        we_tick.push_back(tick_cnt);
        chk(nbits == 9, "R1", "bits per word", nbits, 9);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected word", sh, 0);
        end else begin
          chk(sh == exp_q[0], tag_q[0], "serial word", sh, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
        n_words <= n_words + 1;
      end
      if (prev_rst && !lcd_rst) rel_tick = tick_cnt;
      if (lcd_rst && !lcd_cs_n) chk(1'b0, "R2", "word during panel reset", 0, 1);
      if (lcd_cs_n && lcd_sclk) chk(1'b0, "R12", "sclk high while idle", 1, 0);
      if (ready && n_words < 66) chk(1'b0, "R8", "ready before script end", n_words, 66);
      if (ready && (!lcd_cs_n || lcd_rst)) chk(1'b0, "R8", "link busy while ready", lcd_cs_n, 1);
    end
    prev_sclk = lcd_sclk;
    prev_cs   = lcd_cs_n;
    prev_rst  = lcd_rst;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R8 run incomplete actual=%0d expected=%0d", n_words, 66);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0;
    disp_on_req = 1'b0; disp_off_req = 1'b0; sleep_req = 1'b0;

    add(8'h11, 0, '0, "R4");
    add(8'h36, 1, {8'h00}, "R5");
    add(8'h3A, 1, {8'h66}, "R5");
    add(8'hB2, 5, {8'h0C, 8'h0C, 8'h00, 8'h33, 8'h33}, "R5");
    add(8'hB7, 1, {8'h35}, "R5");
    add(8'hBB, 1, {8'h2B}, "R5");
    add(8'hC0, 1, {8'h2C}, "R5");
    add(8'hC2, 1, {8'h01}, "R5");
    add(8'hC3, 1, {8'h0F}, "R5");
    add(8'hC4, 1, {8'h20}, "R5");
    add(8'hC6, 1, {8'h0F}, "R5");
    add(8'hD0, 2, {8'hA4, 8'hA1}, "R5");
    add(8'hE0, 14, {8'hD0, 8'h0A, 8'h0E, 8'h08, 8'h09, 8'h07, 8'h2D,
                    8'h33, 8'h3D, 8'h34, 8'h0A, 8'h0A, 8'h1B, 8'h28}, "R6");
    add(8'hE1, 14, {8'hD0, 8'h0A, 8'h0F, 8'h08, 8'h08, 8'h07, 8'h2E,
                    8'h54, 8'h40, 8'h34, 8'h09, 8'h0B, 8'h1B, 8'h28}, "R6");
    add(8'h21, 0, '0, "R7");
    add(8'hB0, 2, {8'h11, 8'hF0}, "R7");
    add(8'hB1, 3, {8'hCE, 8'h08, 8'h14}, "R7");

    repeat (5) @(negedge clk);
    // reset state
    chk(lcd_rst == 1'b1, "R2", "reset value of lcd_rst", lcd_rst, 1);
    chk(lcd_cs_n == 1'b1, "R12", "reset value of cs_n", lcd_cs_n, 1);
    chk(lcd_sclk == 1'b0, "R12", "reset value of sclk", lcd_sclk, 0);
    chk(ready == 1'b0, "R8", "reset value of ready", ready, 0);
    repeat (5) @(negedge clk);
    rst_tick0 = tick_cnt;
    rst_n = 1'b1;

    // R10: a request during the settle wait must not leak a word
    while (lcd_rst) @(negedge clk);
    repeat (200) @(negedge clk);
    pulse(1'b1, 1'b1, 1'b1);
    chk(lcd_cs_n == 1'b1 && ready == 1'b0, "R10", "early request ignored", lcd_cs_n, 1);

    wait_ready_settled();
    chk(n_words == 66, "R7", "script length", n_words, 66);
    chk(exp_q.size() == 0, "R8", "script words pending at ready", exp_q.size(), 0);
    chk(rel_tick - rst_tick0 == 30, "R2", "reset hold ticks", rel_tick - rst_tick0, 30);
    chk(ws_tick[0] - rel_tick == 120, "R3", "settle ticks", ws_tick[0] - rel_tick, 120);
    chk(ws_tick[1] - we_tick[0] == 120, "R4", "wake ticks", ws_tick[1] - we_tick[0], 120);
    chk(ws_tick[2] - we_tick[1] == 0, "R4", "no wait after 2nd word", ws_tick[2] - we_tick[1], 0);

    // R9 single requests
    base = n_words;
    exp_q.push_back(9'h029); tag_q.push_back("R9");
    pulse(1'b1, 1'b0, 1'b0);
    chk(ready == 1'b0, "R9", "ready drops after request", ready, 0);
    wait_ready_settled();
    chk(n_words == base + 1, "R9", "display-on word count", n_words - base, 1);

    base = n_words;
    exp_q.push_back(9'h028); tag_q.push_back("R9");
    pulse(1'b0, 1'b1, 1'b0);
    wait_ready_settled();
    chk(n_words == base + 1, "R9", "display-off word count", n_words - base, 1);

    base = n_words;
    exp_q.push_back(9'h010); tag_q.push_back("R9");
    pulse(1'b0, 1'b0, 1'b1);
    wait_ready_settled();
    chk(n_words == base + 1, "R9", "sleep word count", n_words - base, 1);

    // R10: strobe while a requested word is in flight
    base = n_words;
    exp_q.push_back(9'h029); tag_q.push_back("R10");
    pulse(1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    pulse(1'b0, 1'b1, 1'b0);
    wait_ready_settled();
    chk(n_words == base + 1, "R10", "busy request dropped", n_words - base, 1);

    // R11: strobes in the same cycle
    base = n_words;
    exp_q.push_back(9'h010); tag_q.push_back("R11");
    pulse(1'b1, 1'b0, 1'b1);
    wait_ready_settled();
    chk(n_words == base + 1, "R11", "on+sleep one word", n_words - base, 1);

    base = n_words;
    exp_q.push_back(9'h028); tag_q.push_back("R11");
    pulse(1'b1, 1'b1, 1'b0);
    wait_ready_settled();
    chk(n_words == base + 1, "R11", "on+off one word", n_words - base, 1);

    base = n_words;
    exp_q.push_back(9'h010); tag_q.push_back("R11");
    pulse(1'b1, 1'b1, 1'b1);
    wait_ready_settled();
    chk(n_words == base + 1, "R11", "all three one word", n_words - base, 1);
    chk(exp_q.size() == 0, "R9", "request words pending", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule